// File: doc/BRIEF.md
# Feed-Protected PLL Control Registers

This block is a small register file that drives a clock PLL. Software writes the control word (enable, connect) and the configuration word (multiplier M, divider P) through a simple single-cycle write/read port. These writes land in pending registers only. The PLL outputs stay as they are until a two-write unlock sequence on a dedicated feed address copies every pending value into the active set in one step.

The PLL outputs are the enable, the multiplier, the divider and a clock-select request. The clock-select request feeds an external glitch-free clock multiplexer, and it is raised only while both the active enable and the active connect bits are one. A read-only status word reports the active values together with the PLL lock flag, which is brought into the bus clock domain through a two-stage synchroniser. No logic compares lock with the connect path. The block does not wait for lock before connecting, and it does not disconnect when lock drops.

Top module: `pll_feed_regs`

## Requirements
- R1: After reset, all PLL outputs are 0, and reads of the control (address 0), configuration (address 1), status (address 2) and feed (address 3) words all return 0.
- R2: A write to address 0 stores bit 0 as pending enable and bit 1 as pending connect. Bits 31:2 are ignored and read back as 0.
- R3: A write to address 1 stores bits 4:0 as pending multiplier and bits 6:5 as pending divider. Bits 31:7 are ignored and read back as 0.
- R4: Writes to address 0 or 1 leave the PLL outputs and the status word unchanged until a valid feed occurs.
- R5: A valid feed is a write with bits 7:0 = 0xAA to address 3, followed by a write with bits 7:0 = 0x55 to address 3, with no other write between them. Idle cycles between the two writes are allowed. The pending values appear on the outputs and in status from the first clock edge after the 0x55 write is sampled.
- R6: A write to any other address, or a feed write with any value other than 0xAA between the two feed writes, cancels the sequence. A later lone 0x55 then has no effect.
- R7: The clock-select output is 1 exactly when the active enable and the active connect bits are both 1.
- R8: The status word holds the active multiplier in bits 4:0, the active divider in bits 6:5, active enable in bit 8, active connect in bit 9 and lock in bit 10. All other bits read 0.
- R9: A change on the lock input appears in status bit 10 after exactly two rising clock edges.
- R10: The clock-select output does not depend on lock. It can rise while lock is 0, and it stays 1 when lock falls.
- R11: Writes to the status address have no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (2) | Word address: 0 control, 1 configuration, 2 status, 3 feed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pll_lock_i | input | 1 | Lock flag from the PLL, asynchronous |
| pll_en_o | output | 1 | Active PLL enable |
| pll_clk_sel_o | output | 1 | Request to select the PLL clock |
| pll_mul_o | output | 5 | Active multiplier M |
| pll_div_o | output | 2 | Active divider P |

## Verification
The feed detector is exercised with a clean back-to-back key pair, with a key pair separated by idle cycles, with a foreign write between the keys, with a wrong second key, and with a lone second key. These cases separate a correct two-state detector from one that ignores interruptions or fires on the second key alone. Pending writes made with all bits set expose reserved-bit leakage, and checking the outputs before and after each feed separates staged behaviour from direct write-through. Lock is toggled with the PLL connected to measure the exact two-edge synchroniser latency and to confirm that lock has no effect on the connect path.

// File: rtl/pllreg_pkg.sv
package pllreg_pkg;
  localparam int BUS_W = 32;
  localparam int MUL_W = 5;
  localparam int DIV_W = 2;
  localparam int KEY_W = 8;

  localparam int REG_CTRL = 0;
  localparam int REG_CFG  = 1;
  localparam int REG_STAT = 2;
  localparam int REG_FEED = 3;

  localparam logic [KEY_W-1:0] FEED_KEY_A = 8'hAA;
  localparam logic [KEY_W-1:0] FEED_KEY_B = 8'h55;

  localparam int STAT_DIV_LSB = MUL_W;
  localparam int STAT_EN_BIT  = 8;
  localparam int STAT_CON_BIT = 9;
  localparam int STAT_LCK_BIT = 10;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [MUL_W-1:0] mul;
    logic             conn;
    logic             en;
  } pll_set_t;

  localparam pll_set_t PLL_SET_RST = '0;

  function automatic logic [BUS_W-1:0] ctrl_word(input pll_set_t s);
    logic [BUS_W-1:0] w;
    w    = '0;
    w[0] = s.en;
    w[1] = s.conn;
    return w;
  endfunction

  function automatic logic [BUS_W-1:0] cfg_word(input pll_set_t s);
    logic [BUS_W-1:0] w;
    w = '0;
    w[MUL_W-1:0] = s.mul;
    w[STAT_DIV_LSB +: DIV_W] = s.div;
    return w;
  endfunction

  function automatic logic [BUS_W-1:0] stat_word(input pll_set_t s, input logic lk);
    logic [BUS_W-1:0] w;
    w = cfg_word(s);
    w[STAT_EN_BIT]  = s.en;
    w[STAT_CON_BIT] = s.conn;
    w[STAT_LCK_BIT] = lk;
    return w;
  endfunction

  function automatic logic [BUS_W-1:0] stat_mask();
    logic [BUS_W-1:0] w;
    w = '0;
    w[MUL_W+DIV_W-1:0] = '1;
    w[STAT_EN_BIT]  = 1'b1;
    w[STAT_CON_BIT] = 1'b1;
    w[STAT_LCK_BIT] = 1'b1;
    return w;
  endfunction

  function automatic pll_set_t take_ctrl(input pll_set_t s, input logic [BUS_W-1:0] d);
    pll_set_t r;
    r      = s;
    r.en   = d[0];
    r.conn = d[1];
    return r;
  endfunction

  function automatic pll_set_t take_cfg(input pll_set_t s, input logic [BUS_W-1:0] d);
    pll_set_t r;
    r     = s;
    r.mul = d[MUL_W-1:0];
    r.div = d[STAT_DIV_LSB +: DIV_W];
    return r;
  endfunction
endpackage

// File: rtl/pllreg_feed_seq.sv
module pllreg_feed_seq
  import pllreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_any,
  input  logic             wr_feed,
  input  logic [KEY_W-1:0] key,
  output logic             commit
);
  typedef enum logic {FS_IDLE, FS_ARMED} fs_t;
  fs_t st, st_nx;
  logic hit_a, hit_b;

  always_comb begin
    hit_a  = wr_feed && (key == FEED_KEY_A);
    hit_b  = wr_feed && (key == FEED_KEY_B);
    commit = (st == FS_ARMED) && hit_b;
    st_nx  = st;
    if (wr_any) st_nx = hit_a ? FS_ARMED : FS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= FS_IDLE;
    else        st <= st_nx;
  end

  AST_ARM_ONLY_BY_KEY_A: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_ARMED) |-> ($past(hit_a) || $past(st == FS_ARMED))); // R5
  AST_FOREIGN_WRITE_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_ARMED && wr_any && !hit_a) |=> (st == FS_IDLE)); // R6
endmodule

// File: rtl/pllreg_shadow.sv
module pllreg_shadow
  import pllreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_cfg,
  input  logic [BUS_W-1:0] wdata,
  input  logic             commit,
  output pll_set_t         pend,
  output pll_set_t         act
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= PLL_SET_RST;
    end else if (wr_ctrl) begin
      pend <= take_ctrl(pend, wdata);
    end else if (wr_cfg) begin
      pend <= take_cfg(pend, wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      act <= PLL_SET_RST;
    else if (commit) act <= pend;
  end

  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit) |-> $stable(act)); // R4
  AST_ACTIVE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (act == $past(pend))); // R5
endmodule

// File: rtl/pllreg_lock_sync.sv
module pllreg_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

  AST_SYNC_LAST_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    q_o == $past(chain[STAGES-2])); // R9
endmodule

// File: rtl/pll_feed_regs.sv
module pll_feed_regs
  import pllreg_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int SYNC_FF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              pll_lock_i,
  output logic              pll_en_o,
  output logic              pll_clk_sel_o,
  output logic [MUL_W-1:0]  pll_mul_o,
  output logic [DIV_W-1:0]  pll_div_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(REG_CFG);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
  localparam logic [ADDR_W-1:0] A_FEED = ADDR_W'(REG_FEED);

  logic     wr_ctrl, wr_cfg, wr_feed, commit, lock_sync;
  pll_set_t pend, act;

  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
  assign wr_cfg  = bus_we && (bus_addr == A_CFG);
  assign wr_feed = bus_we && (bus_addr == A_FEED);

  pllreg_feed_seq u_feed (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_any  (bus_we),
    .wr_feed (wr_feed),
    .key     (bus_wdata[KEY_W-1:0]),
    .commit  (commit)
  );

  pllreg_shadow u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_ctrl),
    .wr_cfg  (wr_cfg),
    .wdata   (bus_wdata),
    .commit  (commit),
    .pend    (pend),
    .act     (act)
  );

  pllreg_lock_sync #(.STAGES(SYNC_FF)) u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pll_lock_i),
    .q_o   (lock_sync)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_word(pend);
      A_CFG:   bus_rdata = cfg_word(pend);
      A_STAT:  bus_rdata = stat_word(act, lock_sync);
      default: bus_rdata = '0;
    endcase
  end

  assign pll_en_o      = act.en;
  assign pll_clk_sel_o = act.en & act.conn;
  assign pll_mul_o     = act.mul;
  assign pll_div_o     = act.div;

  AST_STATUS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_STAT) |-> ((bus_rdata & ~stat_mask()) == '0)); // R8
  AST_SEL_RISES_ON_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_clk_sel_o) |-> $past(commit)); // R7
  AST_SEL_IGNORES_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pll_clk_sel_o) && !$past(commit)) |-> pll_clk_sel_o); // R10
endmodule

// File: tb/sim_pll_feed_regs.sv
module sim_pll_feed_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        pll_lock_i = 1'b0;
  logic        pll_en_o, pll_clk_sel_o;
  logic [4:0]  pll_mul_o;
  logic [1:0]  pll_div_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pll_feed_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pll_lock_i(pll_lock_i),
    .pll_en_o(pll_en_o), .pll_clk_sel_o(pll_clk_sel_o),
    .pll_mul_o(pll_mul_o), .pll_div_o(pll_div_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic feed();
    wr(2'd3, 32'hAA);
    wr(2'd3, 32'h55);
  endtask

  function automatic logic [31:0] outs();
    return {22'd0, pll_div_o, pll_mul_o, pll_clk_sel_o, pll_en_o, 1'b0};
  endfunction

  function automatic logic [31:0] exp_stat(input int m, input int p, input bit e,
                                           input bit c, input bit l);
    return 32'(m) | (32'(p) << 5) | (32'(e) << 8) | (32'(c) << 9) | (32'(l) << 10);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reset read", d, 32'h0);
    end
    chk("R1 reset outputs", outs(), 32'h0);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R2 ctrl readback", d, 32'h3);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R3 cfg readback", d, 32'h7F);
    chk("R4 outputs staged", outs(), 32'h0);
    rd(2'd2, d); chk("R4 status staged", d, 32'h0);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R11 status write ignored", d, 32'h0);
  endtask

  task automatic t_feed_enable_only();
    logic [31:0] d;
    wr(2'd1, 32'h2A);
    wr(2'd0, 32'h1);
    wr(2'd3, 32'hAA);
    chk("R4 no change after key A", outs(), 32'h0);
    wr(2'd3, 32'h55);
    chk("R5 outputs after feed", outs(), {22'd0, 2'd1, 5'd10, 1'b0, 1'b1, 1'b0});
    chk("R7 no select without connect", 32'(pll_clk_sel_o), 32'h0);
    rd(2'd2, d); chk("R8 status layout", d, exp_stat(10, 1, 1, 0, 0));
  endtask

  task automatic t_cancel();
    logic [31:0] d;
    wr(2'd0, 32'h3);
    wr(2'd3, 32'hAA);
    wr(2'd1, 32'h1F);
    wr(2'd3, 32'h55);
    chk("R6 foreign write cancels", outs(), {22'd0, 2'd1, 5'd10, 1'b0, 1'b1, 1'b0});
    wr(2'd3, 32'hAA);
    wr(2'd3, 32'h56);
    wr(2'd3, 32'h55);
    rd(2'd2, d); chk("R6 wrong key then lone 0x55", d, exp_stat(10, 1, 1, 0, 0));
    wr(2'd3, 32'hAA);
    repeat (3) @(negedge clk);
    wr(2'd3, 32'h55);
    chk("R5 feed with idle gap", outs(), {22'd0, 2'd0, 5'd31, 1'b1, 1'b1, 1'b0});
    chk("R10 select while unlocked", 32'(pll_clk_sel_o), 32'h1);
    rd(2'd2, d); chk("R8 status connected", d, exp_stat(31, 0, 1, 1, 0));
  endtask

  task automatic t_lock();
    logic [31:0] d;
    @(negedge clk);
    pll_lock_i = 1'b1;
    rd(2'd2, d); chk("R9 lock after one edge", d[10], 1'b0);
    rd(2'd2, d); chk("R9 lock after two edges", d[10], 1'b1);
    @(negedge clk);
    pll_lock_i = 1'b0;
    repeat (4) @(negedge clk);
    rd(2'd2, d); chk("R9 lock cleared", d[10], 1'b0);
    chk("R10 select kept after lock loss", 32'(pll_clk_sel_o), 32'h1);
  endtask

  task automatic t_connect_only();
    logic [31:0] d;
    wr(2'd0, 32'h2);
    feed();
    chk("R7 connect without enable", 32'({pll_clk_sel_o, pll_en_o}), 32'h0);
    rd(2'd2, d); chk("R8 status connect only", d, exp_stat(31, 0, 0, 1, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pending();
    t_feed_enable_only();
    t_cancel();
    t_lock();
    t_connect_only();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule